// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is an I2C target that fronts a 128-byte on-chip byte memory. It oversamples SCL and SDA with the system clock, detects Start and Stop conditions, and answers on the bus through an open-drain enable: while `sda_oe` is high the pad pulls SDA low. It responds to the 7-bit target address 1010000 followed by a direction bit. It supports single-byte writes, page writes of up to eight bytes, current-address reads, random reads (the address is set by a write that a repeated Start cuts short), and sequential reads for as long as the controller keeps acknowledging.

Written data is held in a page buffer and lands in the memory only when the Stop that ends the write arrives. A self-timed programming interval then follows, and during it the block refuses its own address, so the controller can poll until it is acknowledged again. A permission input from a separate protection unit is sampled at that Stop: when it is low, the buffered bytes are dropped and no programming interval starts. One address pointer serves both reads and writes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is low, the engine is idle and every memory byte reads as 00h.
- R2: Only a first byte whose upper seven bits equal 1010000 is acknowledged, with bit 0 selecting a read (1) or a write (0). Any other first byte gets no ACK, and the rest of that transfer is ignored up to the next Start.
- R3: In a write, the control byte, the word address (only its low 7 bits are used) and every data byte are acknowledged by pulling SDA low during the ninth clock.
- R4: Data bytes go into a page buffer and reach the memory only at the Stop that ends the transfer. The low 3 address bits advance after each byte and wrap inside the aligned 8-byte page, so a ninth or later byte overwrites an earlier one.
- R5: A Stop that ends a permitted write carrying at least one data byte starts a programming interval of WCYC clocks. During that interval the target address gets no ACK for either direction, and it is acknowledged again once the interval ends.
- R6: When `wr_permit` is low at the Stop, the data bytes are still acknowledged, but the memory keeps its contents and no programming interval starts.
- R7: After a data byte is written, the pointer holds that address plus one, wrapping inside the page. After a byte is read, the pointer is incremented and wraps from 7Fh to 00h. A current-address read returns the byte at the pointer.
- R8: A repeated Start after the word address (or after data bytes) loads the pointer, discards any buffered data and starts no programming interval. A following read then returns data from that pointer.
- R9: Read data is shifted out MSB first and is stable while SCL is high. A controller ACK gets the next sequential byte, and a NACK makes the block release SDA.
- R10: A Stop always returns the engine to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |
| wr_permit | input | 1 | Write permission from the protection unit, sampled at Stop |

## Verification
Both bus lines pass through a two-flop synchronizer and one edge register, so a new ACK or data bit appears on `sda_oe` three clocks after SCL falls. The memory commit and the start of the programming interval come three clocks after the Stop, and the interval then runs for WCYC clocks. The bench holds each SCL phase for eight clocks and samples SDA halfway through the high phase, well clear of those latencies. For the programming interval it checks that the first poll is refused and that the ACK returns within the poll count implied by WCYC and the poll length.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 8,
  parameter int WCYC       = 5000,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wr_permit
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WCYC + 1);

  typedef enum logic [3:0] {
    IDLE, DEV, DEV_ACK, ADR, ADR_ACK, WDAT, WDAT_ACK, RD, RD_ACK
  } st_t;

  st_t st;
  logic [1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic rw, mack;
  logic [AW-1:0] ptr;
  logic [CW-1:0] bcnt;
  logic [PAGE_BYTES-1:0] pmask;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];

  wire s_scl = scl_q[1];
  wire s_sda = sda_q[1];
  wire start = scl_p & s_scl & sda_p & ~s_sda;
  wire stop  = scl_p & s_scl & ~sda_p & s_sda;
  wire scl_rise = ~scl_p & s_scl;
  wire scl_fall = scl_p & ~s_scl;
  wire byte_end = scl_fall && cnt == 4'd8;
  wire busy = bcnt != '0;
  wire commit = stop && (pmask != '0) && wr_permit;
  wire buf_we = byte_end && st == WDAT;
  wire [7:0] rdat = mem[ptr];

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[ptr[PB-1:0]] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{ptr[AW-1:PB], PB'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11;
      scl_p <= 1'b1;  sda_p <= 1'b1;
      st <= IDLE; cnt <= '0; sh <= '0; tx <= '0;
      rw <= 1'b0; mack <= 1'b0; ptr <= '0;
      bcnt <= '0; pmask <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= s_scl;
      sda_p <= s_sda;
      if (busy) bcnt <= bcnt - CW'(1);
      if (stop) begin
        st <= IDLE; sda_oe <= 1'b0; pmask <= '0;
        if (commit) bcnt <= CW'(WCYC);
      end else if (start) begin
        st <= DEV; cnt <= '0; sda_oe <= 1'b0; pmask <= '0;
      end else begin
        case (st)
          DEV, ADR, WDAT: begin
            if (scl_rise) begin
              sh <= {sh[6:0], s_sda};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == DEV) begin
                if (sh[7:1] == DEV_ID && !busy) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= DEV_ACK;
                end else begin
                  st <= IDLE;
                end
              end else if (st == ADR) begin
                ptr <= sh[AW-1:0]; sda_oe <= 1'b1; st <= ADR_ACK;
              end else begin
                pmask[ptr[PB-1:0]] <= 1'b1;
                ptr[PB-1:0] <= ptr[PB-1:0] + 1'b1;
                sda_oe <= 1'b1; st <= WDAT_ACK;
              end
            end
          end
          DEV_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rdat; sda_oe <= ~rdat[7]; st <= RD;
            end else begin
              sda_oe <= 1'b0; st <= ADR;
            end
          end
          ADR_ACK, WDAT_ACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; st <= WDAT;
          end
          RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; ptr <= ptr + 1'b1; st <= RD_ACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          end
          RD_ACK: begin
            if (scl_rise) mack <= ~s_sda;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rdat; sda_oe <= ~rdat[7]; cnt <= '0; st <= RD;
              end else begin
                st <= IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE |-> !sda_oe); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe); // R10
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bcnt == $past(bcnt) - CW'(1)); // R5
  AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV && byte_end && busy) |=> !sda_oe); // R5
  AST_BLOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_permit && !busy) |=> !busy); // R6
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> ptr[AW-1:PB] == $past(ptr[AW-1:PB])); // R4
endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int CLK_P = 10;
  localparam int Q = 8;
  localparam int WC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic permit = 1'b1;
  logic sda_oe;
  wire sda = !(m_low || sda_oe);

  i2c_eeprom_slave #(.WCYC(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .wr_permit(permit)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [128];
  logic [6:0] mptr = '0;
  logic [7:0] wbuf [16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b1; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    end
    m_low = 1'b0; wt(Q); scl = 1'b1; wt(Q/2); ack = !sda; wt(Q/2); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q/2); d[i] = sda; wt(Q/2); scl = 1'b0;
    end
    m_low = mack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q); m_low = 1'b0;
  endtask

  task automatic do_write(input int a, input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, "R3 control ack", ack, 1);
    send_byte(a[7:0], ack); check(ack, "R3 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); check(ack, req, ack, 1);
    end
    i2c_stop();
    check(!sda_oe, "R10 released after stop", sda_oe, 0);
    if (permit)
      for (int k = 0; k < n; k++) mdl[(a & 8'h78) | ((a + k) & 7)] = wbuf[k];
    mptr = 7'((a & 8'h78) | ((a + n) & 7));
  endtask

  task automatic poll_ready(output int polls);
    bit ack;
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 20) begin
      i2c_start(); send_byte(8'hA0, ack); i2c_stop(); polls++;
    end
  endtask

  task automatic read_cur(input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hA1, ack); check(ack, "R2 read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      check(d === mdl[mptr], req, d, mdl[mptr]);
      mptr = mptr + 7'd1;
    end
    check(!sda_oe, "R9 SDA released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic rand_read(input int a, input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, "R8 control ack", ack, 1);
    send_byte(a[7:0], ack); check(ack, "R8 address ack", ack, 1);
    mptr = a[6:0];
    read_cur(n, req);
  endtask

  initial begin
    wt(190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int polls;
    bit ack;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);
    check(!sda_oe, "R1 reset release", sda_oe, 0);
    rand_read(5, 2, "R1 memory cleared");

    // R2: foreign address and its trailing byte are ignored
    i2c_start();
    send_byte(8'hA2, ack); check(!ack, "R2 foreign address nack", ack, 0);
    send_byte(8'h10, ack); check(!ack, "R2 trailing byte ignored", ack, 0);
    i2c_stop();

    // R3 R5: single byte write then busy polling
    wbuf[0] = 8'h3C;
    do_write(8'h10, 1, "R3 data ack");
    i2c_start(); send_byte(8'hA1, ack); i2c_stop();
    check(!ack, "R5 read control nack while busy", ack, 0);
    poll_ready(polls);
    check(polls >= 2 && polls <= 4, "R5 polls until ack", polls, 3);
    rand_read(8'h10, 1, "R3 byte written");

    // R6: protected write
    permit = 1'b0;
    wbuf[0] = 8'hEE;
    do_write(8'h10, 1, "R6 data ack when blocked");
    permit = 1'b1;
    poll_ready(polls);
    check(polls == 1, "R6 no busy after blocked write", polls, 1);
    rand_read(8'h10, 1, "R6 memory unchanged");

    // R8: repeated start after data aborts the write
    i2c_start();
    send_byte(8'hA0, ack); send_byte(8'h20, ack); send_byte(8'h55, ack);
    check(ack, "R8 data ack before abort", ack, 1);
    mptr = 7'h21;
    read_cur(1, "R8 read after repeated start");
    poll_ready(polls);
    check(polls == 1, "R8 no busy after abort", polls, 1);
    rand_read(8'h20, 1, "R8 aborted data not stored");

    // R4 R7: sweep of every page with full page writes
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = 8'((p * 8 + k) * 29 + 7);
      do_write(p * 8, 8, "R4 page data ack");
      poll_ready(polls);
      check(polls >= 2 && polls <= 4, "R5 page write busy", polls, 3);
    end
    rand_read(0, 128, "R9 sequential read of all bytes");

    // R4 R7: page wrap with ten bytes from offset 3
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'hA0 + k);
    do_write(8'h43, 10, "R4 wrapping page ack");
    poll_ready(polls);
    mptr = 7'h45;
    read_cur(1, "R7 pointer after page wrap");
    rand_read(8'h40, 8, "R4 page wrap overwrite");

    // R7: pointer wrap 7Fh to 00h
    rand_read(8'h7E, 1, "R7 read at 7Eh");
    read_cur(3, "R7 pointer wraps to 00h");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule